// File: doc/BRIEF.md
# I2C Target Address-Match Wake Unit

This block watches an I2C bus from the receive side of a target device and tells the host when it has been addressed. It synchronizes the SCL and SDA lines to the system clock and finds start and stop conditions. It counts the serial clocks of each byte and shifts in the received bits. The first byte after a start is compared against a programmable 7-bit own address. The same byte is also checked for the reserved extension-code prefix. Either result selects the target for the rest of the transfer.

While the target is selected, one interrupt pulse is raised per byte. A wait-timing select input places that pulse at the falling edge of the 8th SCL clock or at the falling edge of the 9th (acknowledge) clock. An independent enable adds an interrupt on every detected stop condition. The unit pulls SDA low on the acknowledge clock of bytes it accepts. It changes its SDA drive only a fixed number of system clocks after an SCL falling edge, which gives the required data hold time. Clock stretching and clock generation are not part of the unit.

Top module: `i2c_addr_wake`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one zeroes the bit count. A start opens a transfer whose first byte is the address byte. Clocks and data seen before the first start have no effect on any output.
- R2: On the 8th clock of the address byte, addr_match_o is set when bits [7:1] of that byte equal own_addr_i, and rw_o takes bit [0]. Both flags are cleared by the next start and persist through a stop.
- R3: ext_code_o is set when bits [7:3] of the address byte are 5'b00001, whether or not the address matches. An extension code selects the target just as a match does.
- R4: While the target is selected, irq_o pulses for exactly one clock per byte. With wait_sel_i=0 the pulse follows the falling edge of the 8th SCL clock; with wait_sel_i=1 it follows the falling edge of the 9th.
- R5: A transfer whose address byte neither matches nor carries the extension code raises no byte interrupt and is never acknowledged.
- R6: With stop_irq_en_i=1, every stop condition raises a one-clock irq_o pulse, selected or not. With stop_irq_en_i=0, a stop raises none.
- R7: sda_low_o (1 = pull SDA low) is asserted over the 9th clock of a selected address byte, and of each following byte when rw_o=0. It stays released for bytes of a read transfer.
- R8: sda_low_o changes only while SCL is low. A change takes effect HOLD_CYC+3 system clocks after the SCL falling edge reaches the input pin: two synchronizer stages, one event register, then HOLD_CYC hold clocks.
- R9: rx_byte_o holds the last byte completed by 8 SCL clocks of an open transfer, first bit received as bit 7.
- R10: A repeated start in the middle of a byte discards the partial byte and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| own_addr_i | input | 7 | Own 7-bit target address |
| wait_sel_i | input | 1 | 0: interrupt on 8th clock fall, 1: on 9th clock fall |
| stop_irq_en_i | input | 1 | Enable interrupt on stop condition |
| irq_o | output | 1 | One-clock interrupt request pulse |
| addr_match_o | output | 1 | Address byte matched own address |
| ext_code_o | output | 1 | Address byte was an extension code |
| rw_o | output | 1 | Direction bit of the address byte |
| rx_byte_o | output | 8 | Last received byte |
| sda_low_o | output | 1 | Pull SDA low (acknowledge drive) |

## Verification
The assertions assume that SCL stays in each phase for several system clocks. Under that assumption an SCL falling edge never lands on the clock right after a stop or after another event, so the one-clock width of irq_o and the rule that the drive changes only while SCL is low hold. The assertions also assume that SDA changes only while SCL is low, except at intended start and stop conditions. The bench holds each SCL phase for 16 system clocks, moves SDA only in the low phase, and models the bus as a wired-AND of the controller's SDA and the unit's drive.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int EXT_W  = 5;
  localparam logic [EXT_W-1:0] EXT_PREFIX = 5'b00001;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
  import i2c_wake_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_comb begin
    evt_o.scl      = scl_s;
    evt_o.sda      = sda_s;
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.scl_fall = ~scl_s & scl_q;
    // SDA edges only count as conditions with SCL held high on both samples
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2c_wake_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic              ack_en_i,
  output logic              fall8_o,
  output logic              fall9_o,
  output logic              first_byte_o,
  output logic [BYTE_W-1:0] shreg_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sda_low_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam int HW    = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CLK   = CNT_W'(BYTE_W + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign fall8_o = active_q & evt_i.scl_fall & (cnt_q == DATA_LAST);
  assign fall9_o = active_q & evt_i.scl_fall & (cnt_q == ACK_CLK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      first_byte_o <= 1'b0;
      cnt_q        <= '0;
      shreg_o      <= '0;
      rx_byte_o    <= '0;
    end else if (evt_i.start) begin
      active_q     <= 1'b1;
      first_byte_o <= 1'b1;
      cnt_q        <= '0;
    end else if (evt_i.stop) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (evt_i.scl_rise && cnt_q != ACK_CLK) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q < DATA_LAST) begin
          shreg_o <= {shreg_o[BYTE_W-2:0], evt_i.sda};
          if (cnt_q == DATA_LAST - CNT_W'(1))
            rx_byte_o <= {shreg_o[BYTE_W-2:0], evt_i.sda};
        end
      end else if (fall9_o) begin
        cnt_q        <= '0;
        first_byte_o <= 1'b0;
      end
    end
  end

  // acknowledge drive, applied HOLD_CYC clocks after the SCL fall event
  logic          pend_q, tgt_q;
  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      tgt_q     <= 1'b0;
      hcnt_q    <= '0;
      sda_low_o <= 1'b0;
    end else if (evt_i.start || evt_i.stop) begin
      pend_q    <= 1'b0;
      sda_low_o <= 1'b0;
    end else if (fall8_o || fall9_o) begin
      pend_q <= 1'b1;
      tgt_q  <= fall8_o & ack_en_i;
      hcnt_q <= HW'(HOLD_CYC);
    end else if (pend_q) begin
      if (hcnt_q == HW'(1)) begin
        sda_low_o <= tgt_q;
        pend_q    <= 1'b0;
      end else begin
        hcnt_q <= hcnt_q - HW'(1);
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACK_CLK);
  assert_start_clears_cnt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.start |=> (cnt_q == '0) && first_byte_o);
  assert_drive_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !evt_i.scl);
endmodule

// File: rtl/i2c_wake_ctrl.sv
module i2c_wake_ctrl
  import i2c_wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              fall8_i,
  input  logic              fall9_i,
  input  logic              first_byte_i,
  input  logic [BYTE_W-1:0] shreg_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              wait_sel_i,
  input  logic              stop_irq_en_i,
  output logic              ack_en_o,
  output logic              irq_o,
  output logic              addr_match_o,
  output logic              ext_code_o,
  output logic              rw_o
);
  logic match_now, ext_now, sel_now, byte_evt;

  assign match_now = (shreg_i[BYTE_W-1:1] == own_addr_i);
  assign ext_now   = (shreg_i[BYTE_W-1:BYTE_W-EXT_W] == EXT_PREFIX);
  assign sel_now   = first_byte_i ? (match_now | ext_now) : (addr_match_o | ext_code_o);
  assign ack_en_o  = first_byte_i ? sel_now : (sel_now & ~rw_o);
  assign byte_evt  = wait_sel_i ? fall9_i : fall8_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_match_o <= 1'b0;
      ext_code_o   <= 1'b0;
      rw_o         <= 1'b0;
    end else if (start_i) begin
      addr_match_o <= 1'b0;
      ext_code_o   <= 1'b0;
      rw_o         <= 1'b0;
    end else if (fall8_i && first_byte_i) begin
      addr_match_o <= match_now;
      ext_code_o   <= ext_now;
      rw_o         <= shreg_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (byte_evt & sel_now) | (stop_i & stop_irq_en_i);
  end

  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_stop_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !stop_irq_en_i) |=> !irq_o);
  assert_flags_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !addr_match_o && !ext_code_o);
endmodule

// File: rtl/i2c_addr_wake.sv
module i2c_addr_wake
  import i2c_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              wait_sel_i,
  input  logic              stop_irq_en_i,
  output logic              irq_o,
  output logic              addr_match_o,
  output logic              ext_code_o,
  output logic              rw_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sda_low_o
);
  bus_evt_t          evt;
  logic              fall8, fall9, first_byte, ack_en;
  logic [BYTE_W-1:0] shreg;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  i2c_byte_rx #(.HOLD_CYC(HOLD_CYC)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .ack_en_i    (ack_en),
    .fall8_o     (fall8),
    .fall9_o     (fall9),
    .first_byte_o(first_byte),
    .shreg_o     (shreg),
    .rx_byte_o   (rx_byte_o),
    .sda_low_o   (sda_low_o)
  );

  i2c_wake_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (evt.start),
    .stop_i       (evt.stop),
    .fall8_i      (fall8),
    .fall9_i      (fall9),
    .first_byte_i (first_byte),
    .shreg_i      (shreg),
    .own_addr_i   (own_addr_i),
    .wait_sel_i   (wait_sel_i),
    .stop_irq_en_i(stop_irq_en_i),
    .ack_en_o     (ack_en),
    .irq_o        (irq_o),
    .addr_match_o (addr_match_o),
    .ext_code_o   (ext_code_o),
    .rw_o         (rw_o)
  );

  assert_ack_needs_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_low_o |-> (addr_match_o || ext_code_o));
endmodule

// File: tb/sim_i2c_addr_wake.sv
module sim_i2c_addr_wake;
  localparam int CLK_P = 10;
  localparam int HALF  = 16;
  localparam int HOLD  = 2;
  localparam int NVEC  = 8;

  // {addr byte, own addr, wait_sel, stop_en, exp match, exp ext}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h84, 7'h42, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h85, 7'h42, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h0A, 7'h42, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h0E, 7'h07, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h90, 7'h42, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h90, 7'h42, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hFE, 7'h7F, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h10, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own = '0;
  logic       wsel = 1'b0, sen = 1'b0;
  logic       irq, match, ext, rw, sda_low;
  logic [7:0] rx_byte;
  wire        sda_line = sda_m & ~sda_low;

  i2c_addr_wake #(.HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .own_addr_i(own), .wait_sel_i(wsel), .stop_irq_en_i(sen),
    .irq_o(irq), .addr_match_o(match), .ext_code_o(ext), .rw_o(rw),
    .rx_byte_o(rx_byte), .sda_low_o(sda_low)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int irq_pulses = 0, irq_hi = 0, first_pos = -1, fall_idx = 0, since_fall = 0, hold_bad = 0;
  logic irq_prev = 1'b0, low_prev = 1'b0, in_byte = 1'b0, done = 1'b0;

  always @(posedge clk) since_fall = since_fall + 1;

  always @(negedge clk) begin
    if (irq) begin
      irq_hi = irq_hi + 1;
      if (!irq_prev) begin
        if (irq_pulses == 0) first_pos = fall_idx;
        irq_pulses = irq_pulses + 1;
      end
    end
    irq_prev = irq;
    if (sda_low !== low_prev && in_byte)
      if (scl_m || since_fall != HOLD + 3) hold_bad = hold_bad + 1;
    low_prev = sda_low;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic scl_low(int idx);
    scl_m = 1'b0;
    fall_idx = idx;
    since_fall = 0;
  endtask

  task automatic clear_mon();
    irq_pulses = 0; irq_hi = 0; first_pos = -1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_low(0);   tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF);
    fall_idx = 99;
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    in_byte = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sda_m = b[7-i]; tick(HALF);
      scl_m = 1'b1;   tick(HALF);
      scl_low(i + 1);
    end
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF/2);
    ack = ~sda_line;
    tick(HALF/2);
    scl_low(9); tick(HALF);
    in_byte = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a1, a2;
    logic [7:0] ab;
    tick(3);
    // reset state
    chk("R4 reset irq", irq, 0);
    chk("R2 reset match", match, 0);
    chk("R3 reset ext", ext, 0);
    chk("R7 reset drive", sda_low, 0);
    chk("R9 reset rx", rx_byte, 0);
    rst_n = 1'b1;
    tick(4);

    // R1: traffic before any start is ignored
    own = 7'h42; wsel = 1'b0; sen = 1'b1;
    scl_m = 1'b1; tick(HALF); scl_low(0); tick(HALF);
    clear_mon();
    send_byte(8'h84, a1);
    tick(4);
    chk("R1 no irq before start", irq_pulses, 0);
    chk("R1 no rx before start", rx_byte, 0);
    chk("R1 no ack before start", a1, 0);
    chk("R1 no match before start", match, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] addr;
      logic em, ee, es;
      addr = VEC[v][18:11];
      own  = VEC[v][10:4];
      wsel = VEC[v][3];
      sen  = VEC[v][2];
      em   = VEC[v][1];
      ee   = VEC[v][0];
      es   = em | ee;
      clear_mon();
      bus_start();
      send_byte(addr, a1);
      bus_stop();
      tick(4);
      chk("R2 match", match, em);
      chk("R3 ext code", ext, ee);
      chk("R2 rw bit", rw, addr[0]);
      chk("R9 rx byte", rx_byte, addr);
      chk("R5 R6 irq count", irq_pulses, 32'(es) + 32'(sen));
      chk("R4 pulse width", irq_hi, irq_pulses);
      if (es) chk("R4 irq position", first_pos, wsel ? 9 : 8);
      else if (sen) chk("R6 stop irq position", first_pos, 99);
      chk("R7 R5 ack", a1, es);
    end

    // R7 R9: selected write, data byte acknowledged
    own = 7'h42; wsel = 1'b1; sen = 1'b0;
    clear_mon();
    bus_start(); send_byte(8'h84, a1); send_byte(8'hA5, a2); bus_stop(); tick(4);
    chk("R7 write addr ack", a1, 1);
    chk("R7 write data ack", a2, 1);
    chk("R9 data byte", rx_byte, 8'hA5);
    chk("R4 irq per byte", irq_pulses, 2);

    // R7: read transfer, following byte not acknowledged
    clear_mon();
    bus_start(); send_byte(8'h85, a1); send_byte(8'h3C, a2); bus_stop(); tick(4);
    chk("R7 read addr ack", a1, 1);
    chk("R7 read data no ack", a2, 0);
    chk("R2 rw read", rw, 1);
    chk("R4 read irq count", irq_pulses, 2);

    // R5 R2: unselected transfer clears previous flags
    clear_mon();
    bus_start(); send_byte(8'h90, a1); send_byte(8'h11, a2); bus_stop(); tick(4);
    chk("R2 flags cleared by start", match, 0);
    chk("R5 no irq unselected", irq_pulses, 0);
    chk("R5 no ack data", a2, 0);
    chk("R9 unselected rx", rx_byte, 8'h11);

    // R10: repeated start inside a byte
    wsel = 1'b0;
    clear_mon();
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_low(i + 1);
    end
    tick(HALF);
    bus_start();
    ab = 8'h84;
    send_byte(ab, a1); bus_stop(); tick(4);
    chk("R10 match after restart", match, 1);
    chk("R10 ack after restart", a1, 1);
    chk("R10 irq after restart", irq_pulses, 1);
    chk("R10 irq position", first_pos, 8);
    chk("R10 rx byte", rx_byte, ab);

    chk("R8 drive timing", hold_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule